// File: doc/BRIEF.md
# Bus Timebase Prescaler with Four-Times Compensation

This block produces the 1 MHz timing tick used by a variable-pulse-width serial bus interface. It derives the tick from a system clock that runs at an integer number of MHz. One 8-bit configuration register, written through a plain write strobe, holds a divider value `F` and a four-times flag. The prescaler divides the system clock by `F + 1`, so `F` is one less than the clock frequency in MHz. The register reads back through a parallel output.

The block also contains two long-duration timers, and each one counts ticks. The break timer measures the nominal 300 µs break symbol. The timeout timer measures the nominal 1 ms transmit timeout. Each timer starts on a one-cycle strobe and ends with a one-cycle done pulse.

In the diagnostic four-times mode, software writes a divider that is four times smaller, so the tick runs four times faster. Setting the flag does not change the divider by itself. To keep the break and the timeout at their real-time lengths, the two timers then count four times as many ticks.

The divider and the flag are written together in one write. Any write that changes either of them does three things: it restarts the prescaler from zero, it stops any timer that is running, and it drops a start strobe that arrives in the same cycle. A write that leaves both values unchanged has no effect on any of these. A start strobe given to a timer that is already running restarts that timer's count from zero.

Top module: `vpw_timebase`

## Requirements
- R1: After reset the register reads 00h, `tick` is high on every cycle (divide by 1), and neither done output pulses.
- R2: `tick` is high for one cycle in every `F+1` cycles, where `F` is register bits 5:0. When `F = 0`, `tick` is high on every cycle.
- R3: Register bit 7 is the four-times flag and bits 5:0 are `F`. Bit 6 is reserved: writes to it are ignored and it reads 0. For example, writing FFh reads back BFh.
- R4: Setting the four-times flag while `F` stays the same does not change the tick period.
- R5: With the flag clear, `brk_done` pulses for exactly one cycle, in the cycle after the 300th tick that the break timer samples after `brk_start`.
- R6: With the flag clear, `tmo_done` pulses for exactly one cycle, in the cycle after the 1000th tick that the timeout timer samples after `tmo_start`.
- R7: With the flag set, the break timer counts 1200 ticks and the timeout timer counts 4000 ticks.
- R8: A write that changes `F` or the flag restarts the prescaler from count 0, so the first new tick comes in the `(F+1)`th cycle after the write edge. The same write aborts any running timer, which then gives no done pulse, and it drops a start strobe that arrives in the same cycle.
- R9: A write whose bit 7 and bits 5:0 equal the stored values neither restarts the prescaler nor aborts a running timer.
- R10: A start strobe given to a running timer restarts its count, so done follows the full tick count measured from the last strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, an integer number of MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write data: bit 7 is the four-times flag, bits 5:0 are `F` |
| cfg_rdata | output | 8 | Register readback; bit 6 always reads 0 |
| brk_start | input | 1 | One-cycle strobe that starts the break timer |
| tmo_start | input | 1 | One-cycle strobe that starts the timeout timer |
| tick | output | 1 | Single-cycle 1 MHz bus tick (4 MHz in four-times mode) |
| brk_done | output | 1 | One-cycle pulse when the break duration ends |
| tmo_done | output | 1 | One-cycle pulse when the timeout expires |

## Verification
The embedded properties check several rules on every cycle:
- the prescaler count never exceeds the programmed divider;
- a configuration change always reloads the prescaler and leaves the timers silent on the next cycle;
- a done pulse never lasts longer than one cycle;
- a running timer's count stays below its terminal count for the current mode;
- an unchanged write leaves the register stable.

Only the directed scenarios can show the end-to-end figures:
- the exact tick period for several divider values;
- the 300, 1000, 1200 and 4000 tick durations;
- the restart behaviour;
- that an aborted timer never completes.

// File: rtl/vpw_tbase_pkg.sv
package vpw_tbase_pkg;
  localparam int unsigned DIV_W     = 6;
  localparam int unsigned BRK_TICKS = 300;
  localparam int unsigned TMO_TICKS = 1000;
  localparam int unsigned FAST_MUL  = 4;

  typedef struct packed {
    logic             fast;
    logic [DIV_W-1:0] div;
  } tb_cfg_t;
endpackage

// File: rtl/vpw_tbase_cfg.sv
module vpw_tbase_cfg
  import vpw_tbase_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output tb_cfg_t    cfg_o,
  output logic       chg_o,
  output logic [7:0] rdata_o
);
  tb_cfg_t cfg_q;
  tb_cfg_t cfg_new;

  always_comb begin
    cfg_new.fast = wdata_i[7];
    cfg_new.div  = wdata_i[DIV_W-1:0];
  end

  assign chg_o = wr_i && (cfg_new != cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (chg_o) cfg_q <= cfg_new;
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {cfg_q.fast, 1'b0, cfg_q.div};

  // R9: no change strobe means the readback holds
  a_r9_same_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_o |=> $stable(rdata_o));
endmodule

// File: rtl/vpw_tbase_presc.sv
module vpw_tbase_presc #(
  parameter int unsigned DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] div_i,
  input  logic          reload_i,
  output logic          tick_o
);
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (reload_i)        cnt_q <= '0;
    else if (cnt_q == div_i)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == div_i);

  // R2: count never passes the divider
  a_r2_cnt_within_div: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div_i);
  // R8: configuration change restarts the count
  a_r8_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> cnt_q == '0);
endmodule

// File: rtl/vpw_tbase_dur.sv
module vpw_tbase_dur #(
  parameter int unsigned NOM = 300,
  parameter int unsigned MUL = 4,
  parameter int unsigned CW  = $clog2(NOM*MUL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast_i,
  input  logic tick_i,
  input  logic start_i,
  input  logic abort_i,
  output logic done_o
);
  localparam logic [CW-1:0] TERM_N = CW'(NOM);
  localparam logic [CW-1:0] TERM_F = CW'(NOM*MUL);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term;

  assign term = fast_i ? TERM_F : TERM_N;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q && tick_i) begin
        if (cnt_q == term - 1'b1) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R5: done lasts one cycle
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R7: running count stays below the mode's terminal count
  a_r7_cnt_below_term: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q < term);
  // R8: an abort silences the timer
  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !done_o && !busy_q);
endmodule

// File: rtl/vpw_timebase.sv
module vpw_timebase
  import vpw_tbase_pkg::*;
#(
  parameter int unsigned BRK_NOM = BRK_TICKS,
  parameter int unsigned TMO_NOM = TMO_TICKS,
  parameter int unsigned MUL     = FAST_MUL
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic       brk_start,
  input  logic       tmo_start,
  output logic       tick,
  output logic       brk_done,
  output logic       tmo_done
);
  localparam int unsigned NT = 2;
  localparam int unsigned NOMS [NT] = '{BRK_NOM, TMO_NOM};

  tb_cfg_t        cfg;
  logic           chg;
  logic [NT-1:0]  starts;
  logic [NT-1:0]  dones;

  vpw_tbase_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr), .wdata_i(cfg_wdata),
    .cfg_o(cfg), .chg_o(chg), .rdata_o(cfg_rdata)
  );

  vpw_tbase_presc #(.DW(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .div_i(cfg.div), .reload_i(chg), .tick_o(tick)
  );

  assign starts = {tmo_start, brk_start};

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    vpw_tbase_dur #(.NOM(NOMS[g]), .MUL(MUL)) u_dur (
      .clk(clk), .rst_n(rst_n), .fast_i(cfg.fast), .tick_i(tick),
      .start_i(starts[g]), .abort_i(chg), .done_o(dones[g])
    );
  end

  assign brk_done = dones[0];
  assign tmo_done = dones[1];
endmodule

// File: tb/test_vpw_timebase.sv
`timescale 1ns/1ps
module test_vpw_timebase;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       brk_start = 1'b0;
  logic       tmo_start = 1'b0;
  logic       tick, brk_done, tmo_done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  vpw_timebase i_vpw_timebase (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .brk_start(brk_start), .tmo_start(tmo_start),
    .tick(tick), .brk_done(brk_done), .tmo_done(tmo_done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(posedge clk); #1 cfg_wr = 1'b1; cfg_wdata = d;
    @(posedge clk); #1 cfg_wr = 1'b0;
  endtask

  task automatic pulse(input bit tmo);
    @(posedge clk); #1 if (tmo) tmo_start = 1'b1; else brk_start = 1'b1;
    @(posedge clk); #1 tmo_start = 1'b0; brk_start = 1'b0;
  endtask

  task automatic measure_period(output int p);
    p = 0;
    @(negedge clk);
    while (!tick) @(negedge clk);
    do begin @(negedge clk); p++; end while (!tick && p < 200);
  endtask

  // counts ticks from start to done; returns -1 on no done
  task automatic run_timer(input bit tmo, input int lim, output int n, output int last_tick);
    logic d;
    int c = 0;
    n = 0; last_tick = 0;
    @(negedge clk);
    d = tmo ? tmo_done : brk_done;
    while (!d && c < lim) begin
      if (tick) n++;
      last_tick = tick;
      c++;
      @(negedge clk);
      d = tmo ? tmo_done : brk_done;
    end
    if (!d) n = -1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 rdata", cfg_rdata, 0);
    check("R1 tick", tick, 1);
    check("R1 done", brk_done | tmo_done, 0);
  endtask

  task automatic t_period;
    int p;
    for (int f = 0; f < 8; f += 3) begin
      wr(8'(f));
      measure_period(p);
      check($sformatf("R2 period F=%0d", f), p, f + 1);
    end
    wr(8'd9);
    measure_period(p);
    check("R2 period F=9", p, 10);
  endtask

  task automatic t_readback;
    wr(8'hFF);
    @(negedge clk);
    check("R3 rdata FF", cfg_rdata, 8'hBF);
    wr(8'h45);
    @(negedge clk);
    check("R3 rdata 45", cfg_rdata, 8'h05);
  endtask

  task automatic t_fast_no_div;
    int p;
    wr(8'h04);
    wr(8'h84);
    measure_period(p);
    check("R4 period fast F=4", p, 5);
  endtask

  task automatic t_timer(input bit tmo, input logic [7:0] cfg, input int exp, input string req);
    int n, lt;
    wr(cfg);
    pulse(tmo);
    run_timer(tmo, 20000, n, lt);
    check({req, " tick count"}, n, exp);
    check({req, " done after tick"}, lt, 1);
    @(negedge clk);
    check({req, " done width"}, tmo ? tmo_done : brk_done, 0);
  endtask

  task automatic t_reload;
    int k = 0;
    wr(8'h05);
    repeat (3) @(negedge clk);
    wr(8'h04);
    @(negedge clk);
    while (!tick && k < 50) begin k++; @(negedge clk); end
    check("R8 first tick index", k, 4);
  endtask

  task automatic t_abort;
    int n, lt;
    wr(8'h00);
    pulse(1'b1);
    repeat (50) @(negedge clk);
    wr(8'h01);
    run_timer(1'b1, 2500, n, lt);
    check("R8 aborted timeout silent", n, -1);
    pulse(1'b0);
    repeat (20) @(negedge clk);
    wr(8'h00);
    run_timer(1'b0, 800, n, lt);
    check("R8 aborted break silent", n, -1);
  endtask

  task automatic t_same;
    int n, lt, k = 0;
    wr(8'h02);
    pulse(1'b0);
    repeat (31) @(negedge clk);
    wr(8'h42);
    run_timer(1'b0, 2000, n, lt);
    check("R9 same write no abort", (n > 0) ? 1 : 0, 1);
    // tick phase continues: with F=2 the period stays 3 across a same write
    @(negedge clk);
    while (!tick) @(negedge clk);
    wr(8'h02);
    // write edge one cycle after tick (k=1 at edge) ; count to next tick
    @(negedge clk);
    while (!tick && k < 10) begin k++; @(negedge clk); end
    check("R9 no reload", (k < 2) ? 1 : 0, 1);
  endtask

  task automatic t_restart;
    int n, lt, seen = 0;
    wr(8'h00);
    pulse(1'b0);
    repeat (100) @(negedge clk);
    pulse(1'b0);
    run_timer(1'b0, 2000, n, lt);
    check("R10 restart count", n, 300);
  endtask

  initial begin : wdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected < 190000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_period();
    t_readback();
    t_fast_no_div();
    t_timer(1'b0, 8'h00, 300,  "R5 break F=0");
    t_timer(1'b0, 8'h05, 300,  "R5 break F=5");
    t_timer(1'b1, 8'h00, 1000, "R6 timeout F=0");
    t_timer(1'b1, 8'h02, 1000, "R6 timeout F=2");
    t_timer(1'b0, 8'h83, 1200, "R7 fast break");
    t_timer(1'b1, 8'h83, 4000, "R7 fast timeout");
    t_reload();
    t_abort();
    t_same();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule